// File: doc/BRIEF.md
# Parallel Camera Pixel Word Packer

This block sits behind a parallel camera port and turns a stream of pixel samples into 32-bit words for a downstream FIFO or bus. All of its state is clocked by the camera's pixel clock, and samples are taken on the falling edge. A sample is accepted only while capture is enabled and neither sync line (horizontal or vertical, both high-active) is asserted. Accepted samples are packed from the lowest lane upward, and a finished word is presented together with a one-cycle valid strobe.

Two sample widths are supported. In narrow mode each sample is one byte and four of them make a word. In wide mode each sample is ten bits, zero-extended into a 16-bit halfword, and two of them make a word. The width code is taken from its input only while vertical sync is active, so a frame is packed with one width from start to finish. Each new frame throws away any unfinished word, so the first sample of a frame always lands in the lowest lane.

Top module: `cam_word_packer`

## Requirements
- R1: While reset is asserted and after it is released, word_valid is 0 and word_out is 0 until the first word completes; the sample count starts at zero and the width setting starts as 8-bit (code 2'b00).
- R2: A sample is taken on a falling edge of pix_clk only when cap_en is 1, hsync is 0 and vsync is 0 at that edge.
- R3: With width code 2'b00, each sample is pix_data[7:0] and pix_data[13:8] have no effect; four samples make a word, the first in word_out[7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R4: With width code 2'b01, each sample is pix_data[9:0] and pix_data[13:10] have no effect; two samples make a word, the first in word_out[9:0] and the second in [25:16], with word_out[15:10] and [31:26] zero.
- R5: word_valid is 1 for exactly one pix_clk cycle, following the falling edge that takes the last sample of a word; word_out changes at that edge and holds its value until the next word completes.
- R6: hsync high pauses sampling without clearing the partial word, so a word may span the end of a line.
- R7: vsync high clears the sample count and discards any partial word; hsync and vsync rising and falling on the same edge behave the same way.
- R8: The width code is taken from width_mode only on falling edges where vsync is high; changes while vsync is low have no effect on packing.
- R9: With width codes 2'b10 and 2'b11 no sample is taken and no word is produced.
- R10: cap_en low blocks sampling and leaves the partial word and count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with pix_clk |
| cap_en | input | 1 | Capture enable |
| hsync | input | 1 | Horizontal sync, high-active blanking |
| vsync | input | 1 | Vertical sync, high-active; starts a new frame |
| width_mode | input | 2 | Sample width code: 00 8-bit, 01 10-bit, others capture nothing |
| pix_data | input | 14 | Camera data bus |
| word_out | output | 32 | Last completed packed word |
| word_valid | output | 1 | One-cycle strobe marking a new word_out |

## Verification
The hardest state to reach from the ports is a frame boundary landing in the middle of a word while both sync lines switch on the same edge, followed by a width code that changes while vertical sync is low. The stimulus builds three samples of a word, raises and drops hsync and vsync together, then refills the word and checks that only the new samples appear in order; later it flips the width code inside a frame and confirms that words keep the frame's original layout. Full sweeps of all 256 byte values and all 1024 ten-bit values run with the unused upper data bits deliberately scrambled, and with horizontal-sync gaps and enable gaps sprinkled in at odd intervals.

// File: rtl/cam_pack_pkg.sv
package cam_pack_pkg;

  typedef enum logic [1:0] {
    WM_NARROW = 2'b00,
    WM_WIDE   = 2'b01,
    WM_RSV_A  = 2'b10,
    WM_RSV_B  = 2'b11
  } width_mode_e;

  function automatic logic mode_supported(input width_mode_e m);
    return (m == WM_NARROW) || (m == WM_WIDE);
  endfunction

endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync (
  input  logic clk_n_edge,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(negedge clk_n_edge or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cam_sync_qual.sv
module cam_sync_qual
  import cam_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic        hsync,
  input  logic        vsync,
  input  logic [1:0]  width_mode,
  output width_mode_e mode_q,
  output logic        take,
  output logic        frame_clr
);
  width_mode_e mode_d;
  logic        mode_en;

  // Width code is only accepted during vertical blanking.
  always_comb begin
    mode_en = vsync;
    mode_d  = mode_q;
    if (mode_en) mode_d = width_mode_e'(width_mode);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WM_NARROW;
    else        mode_q <= mode_d;
  end

  always_comb begin
    frame_clr = vsync;
    take      = cap_en && !hsync && !vsync && mode_supported(mode_q);
  end
endmodule

// File: rtl/cam_lane_pack.sv
module cam_lane_pack
  import cam_pack_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clr,
  input  width_mode_e       mode,
  input  logic [DATA_W-1:0] pix_data,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);
  localparam int HALF_W   = WORD_W / 2;
  localparam int N_NARROW = WORD_W / NARROW_W;
  localparam int N_WIDE   = WORD_W / HALF_W;
  localparam int CNT_W    = $clog2(N_NARROW);
  localparam int PAD_W    = HALF_W - WIDE_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] narrow_merged, wide_merged, merged;
  logic              is_wide, last;

  // Narrow lanes: the lane selected by the count takes the new byte.
  for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow_lane
    assign narrow_merged[i*NARROW_W +: NARROW_W] =
      (cnt_q == CNT_W'(i)) ? pix_data[NARROW_W-1:0]
                           : acc_q[i*NARROW_W +: NARROW_W];
  end

  // Wide lanes: a zero-extended halfword per sample.
  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide_lane
    assign wide_merged[j*HALF_W +: HALF_W] =
      (cnt_q == CNT_W'(j)) ? {{PAD_W{1'b0}}, pix_data[WIDE_W-1:0]}
                           : acc_q[j*HALF_W +: HALF_W];
  end

  always_comb begin
    is_wide = (mode == WM_WIDE);
    merged  = is_wide ? wide_merged : narrow_merged;
    last    = is_wide ? (cnt_q == CNT_W'(N_WIDE - 1))
                      : (cnt_q == CNT_W'(N_NARROW - 1));
  end

  always_comb begin
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (take) begin
      if (last) begin
        word_d  = merged;
        valid_d = 1'b1;
        cnt_d   = '0;
        acc_d   = '0;
      end else begin
        acc_d = merged;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_out   = word_q;
  assign word_valid = valid_q;
endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer
  import cam_pack_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 10
) (
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [1:0]        width_mode,
  input  logic [DATA_W-1:0] pix_data,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);
  logic        srst_n;
  width_mode_e mode_q;
  logic        take;
  logic        frame_clr;

  cam_rst_sync u_rst (
    .clk_n_edge (pix_clk),
    .arst_n     (rst_n),
    .srst_n     (srst_n)
  );

  cam_sync_qual u_qual (
    .clk        (pix_clk),
    .rst_n      (srst_n),
    .cap_en     (cap_en),
    .hsync      (hsync),
    .vsync      (vsync),
    .width_mode (width_mode),
    .mode_q     (mode_q),
    .take       (take),
    .frame_clr  (frame_clr)
  );

  cam_lane_pack #(
    .DATA_W   (DATA_W),
    .WORD_W   (WORD_W),
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) u_pack (
    .clk        (pix_clk),
    .rst_n      (srst_n),
    .take       (take),
    .clr        (frame_clr),
    .mode       (mode_q),
    .pix_data   (pix_data),
    .word_out   (word_out),
    .word_valid (word_valid)
  );
endmodule

// File: rtl/cam_word_packer_chk.sv
module cam_word_packer_chk
  import cam_pack_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int WORD_W = 32
) (
  input logic              pix_clk,
  input logic              srst_n,
  input logic              cap_en,
  input logic              hsync,
  input logic              vsync,
  input logic [DATA_W-1:0] pix_data,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid,
  input width_mode_e       mode_q
);
  // R2: a word only completes on an edge that took a sample
  a_r2_valid_needs_sample: assert property (@(negedge pix_clk) disable iff (!srst_n)
    word_valid |-> $past(cap_en && !hsync && !vsync));

  // R5: strobe never lasts two cycles
  a_r5_single_pulse: assert property (@(negedge pix_clk) disable iff (!srst_n)
    word_valid |=> !word_valid);

  // R3: last narrow sample lands in the top byte
  a_r3_top_byte: assert property (@(negedge pix_clk) disable iff (!srst_n)
    (word_valid && mode_q == WM_NARROW) |-> word_out[31:24] == $past(pix_data[7:0]));

  // R4: last wide sample lands in the upper halfword, pads zero
  a_r4_upper_half: assert property (@(negedge pix_clk) disable iff (!srst_n)
    (word_valid && mode_q == WM_WIDE) |->
      (word_out[25:16] == $past(pix_data[9:0]) &&
       word_out[31:26] == 6'd0 && word_out[15:10] == 6'd0));

  // R7: a frame start leaves no partial word to finish on the next sample
  a_r7_frame_restart: assert property (@(negedge pix_clk) disable iff (!srst_n)
    $past(vsync, 2) |-> !word_valid);

  // R8: width only moves after an edge with vsync high
  a_r8_mode_frozen: assert property (@(negedge pix_clk) disable iff (!srst_n)
    !$past(vsync) |-> $stable(mode_q));

  // R9: unsupported codes never yield a word
  a_r9_no_word_reserved: assert property (@(negedge pix_clk) disable iff (!srst_n)
    (mode_q == WM_RSV_A || mode_q == WM_RSV_B) |=> !word_valid);
endmodule

bind cam_word_packer cam_word_packer_chk #(
  .DATA_W (DATA_W),
  .WORD_W (WORD_W)
) i_chk (
  .pix_clk    (pix_clk),
  .srst_n     (srst_n),
  .cap_en     (cap_en),
  .hsync      (hsync),
  .vsync      (vsync),
  .pix_data   (pix_data),
  .word_out   (word_out),
  .word_valid (word_valid),
  .mode_q     (mode_q)
);

// File: tb/test_cam_word_packer.sv
`timescale 1ns/1ps
module test_cam_word_packer;
  logic        pix_clk = 1'b0;
  logic        rst_n;
  logic        cap_en, hsync, vsync;
  logic [1:0]  width_mode;
  logic [13:0] pix_data;
  logic [31:0] word_out;
  logic        word_valid;

  int checks = 0;
  int fails  = 0;

  // bench model of the requirements
  logic [1:0]  m_mode;
  int          m_cnt;
  logic [31:0] m_acc;
  logic [31:0] m_last;

  always #10 pix_clk = ~pix_clk;

  cam_word_packer i_cam_word_packer (
    .pix_clk    (pix_clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .hsync      (hsync),
    .vsync      (vsync),
    .width_mode (width_mode),
    .pix_data   (pix_data),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One pixel clock: drive after rising edge, evaluate after falling edge.
  task automatic step(input logic [13:0] d, input logic h, input logic v,
                      input logic en, input logic [1:0] m, input string req);
    logic exp_valid;
    int   lanes;
    @(posedge pix_clk); #1;
    pix_data = d; hsync = h; vsync = v; cap_en = en; width_mode = m;
    @(negedge pix_clk); #2;
    exp_valid = 1'b0;
    if (v) begin
      m_mode = m; m_cnt = 0; m_acc = '0;
    end else if (en && !h && (m_mode == 2'b00 || m_mode == 2'b01)) begin
      lanes = (m_mode == 2'b00) ? 4 : 2;
      if (m_mode == 2'b00) m_acc = m_acc | (32'(d[7:0]) << (8 * m_cnt));
      else                 m_acc = m_acc | (32'(d[9:0]) << (16 * m_cnt));
      m_cnt++;
      if (m_cnt == lanes) begin
        exp_valid = 1'b1; m_last = m_acc; m_acc = '0; m_cnt = 0;
      end
    end
    check({req, " R5 strobe"}, {31'd0, word_valid}, {31'd0, exp_valid});
    check({req, " word"}, word_out, m_last);
  endtask

  task automatic frame(input logic [1:0] m, input string req);
    step(14'h3FFF, 1'b0, 1'b1, 1'b0, m, req);
    step(14'h3FFF, 1'b0, 1'b1, 1'b1, m, req);
  endtask

  initial begin
    repeat (100000) @(posedge pix_clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_en = 1'b0; hsync = 1'b0; vsync = 1'b0;
    width_mode = 2'b00; pix_data = '0;
    m_mode = 2'b00; m_cnt = 0; m_acc = '0; m_last = '0;
    repeat (3) @(negedge pix_clk);
    #2;
    check("R1 reset valid", {31'd0, word_valid}, 32'd0);
    check("R1 reset word", word_out, 32'd0);
    @(posedge pix_clk); #1; rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(14'h1234, 1'b0, 1'b0, 1'b0, 2'b00, "R1 idle");

    // R1: default width is 8-bit without any frame start
    for (int k = 0; k < 4; k++) step(14'(8'hA0 + k) | 14'h2F00, 1'b0, 1'b0, 1'b1, 2'b01, "R1 default");

    // R3 sweep with R6 hsync gaps and R10 enable gaps
    frame(2'b00, "R3");
    for (int i = 0; i < 256; i++) begin
      if (i % 37 == 5) step(14'h0055, 1'b1, 1'b0, 1'b1, 2'b00, "R6 hsync");
      if (i % 23 == 7) step(14'h00AA, 1'b0, 1'b0, 1'b0, 2'b00, "R10 cap_en");
      step({i[5:0] ^ 6'h2A, i[7:0]}, 1'b0, 1'b0, 1'b1, 2'b00, "R3 R2");
    end

    // R4 sweep, upper bits scrambled
    frame(2'b01, "R4");
    for (int i = 0; i < 1024; i++) begin
      if (i % 41 == 3) step(14'h3FFF, 1'b1, 1'b0, 1'b1, 2'b01, "R6 hsync wide");
      if (i % 29 == 11) step(14'h3C00, 1'b0, 1'b0, 1'b0, 2'b01, "R10 wide");
      step({~i[3:0], i[9:0]}, 1'b0, 1'b0, 1'b1, 2'b01, "R4 R2");
    end

    // R7: partial word discarded, both syncs switching together
    frame(2'b00, "R7");
    for (int k = 0; k < 3; k++) step(14'(8'h11 * (k + 1)), 1'b0, 1'b0, 1'b1, 2'b00, "R7 partial");
    step(14'h0000, 1'b1, 1'b1, 1'b1, 2'b00, "R7 both high");
    for (int k = 0; k < 4; k++) step(14'(8'hC0 + k), 1'b0, 1'b0, 1'b1, 2'b00, "R7 refill");
    frame(2'b01, "R7 wide");
    step(14'h0123, 1'b0, 1'b0, 1'b1, 2'b01, "R7 wide partial");
    step(14'h0000, 1'b1, 1'b1, 1'b1, 2'b01, "R7 wide both");
    step(14'h02AB, 1'b0, 1'b0, 1'b1, 2'b01, "R7 wide refill");
    step(14'h0155, 1'b0, 1'b0, 1'b1, 2'b01, "R7 wide refill");

    // R8: width change mid-frame is ignored
    frame(2'b00, "R8");
    for (int k = 0; k < 8; k++) step(14'h3300 | 14'(k * 9), 1'b0, 1'b0, 1'b1, 2'b01, "R8 narrow kept");
    frame(2'b01, "R8 wide");
    for (int k = 0; k < 4; k++) step(14'(10'h3F0 + k), 1'b0, 1'b0, 1'b1, 2'b00, "R8 wide kept");

    // R9: reserved codes capture nothing
    frame(2'b10, "R9");
    for (int k = 0; k < 8; k++) step(14'(k), 1'b0, 1'b0, 1'b1, 2'b10, "R9 code2");
    frame(2'b11, "R9");
    for (int k = 0; k < 8; k++) step(14'(k), 1'b0, 1'b0, 1'b1, 2'b11, "R9 code3");
    frame(2'b00, "R9 recover");
    for (int k = 0; k < 4; k++) step(14'(8'h5A + k), 1'b0, 1'b0, 1'b1, 2'b00, "R9 recover");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule